// File: doc/BRIEF.md
# Descriptor Ring Submission Unit

This block is the producer side of a descriptor ring that feeds a memory-copy engine. A requester strobes copy or fill jobs into it. Each job carries a source address or a 64-bit fill pattern, a destination address, a length and two opaque handles. The unit checks free ring space against the consumer's read index. If there is room, it writes a 64-byte descriptor into the ring memory and keeps the handle pair in a parallel handle memory. If the ring is full, it refuses the job.

Two further commands act on the newest descriptor after it has been written. A fence command sets that descriptor's ordering flag. A start command forces a completion-status update on that descriptor and then rings the doorbell with the free-running write index. The ring size is a power of two, and the read and write indices run freely over 16 bits. One slot always stays empty so that a full ring can be told apart from an empty one.

A registered peek port reads back any slot's descriptor and handle pair. Three counters track accepted jobs, refused jobs and the accepted count at the last doorbell.

Top module: `desc_ring_submit`

## Requirements
- R1: After reset the write index is 0, all three counters are 0, no enqueue response or doorbell pulse is present, and every slot's fence and completion-update flags are clear.
- R2: `space` equals (2^RING_LOG2 − 1) − (wr_idx − rd_idx), computed modulo 2^16. An enqueue strobe while `space` is nonzero is accepted: wr_idx increases by 1 and the accepted counter increases by 1. One cycle after the strobe, resp_valid=1 and resp_accept=1.
- R3: An enqueue strobe while `space` is 0 is refused. One cycle later resp_valid=1 and resp_accept=0, and the refused counter increases by 1. wr_idx does not change, and the slot at wr_idx & (2^RING_LOG2−1) keeps its earlier contents.
- R4: An accepted job is written to slot wr_idx & (2^RING_LOG2−1). The descriptor layout is: bits [31:0] length, [63:32] control word, [127:64] source, [191:128] destination, [255:192] next pointer (zero) and [511:256] zero.
- R5: Control bits [31:24] hold the opcode, 8'h00 for copy and 8'h01 for fill. A fill puts the pattern in the source field and stores a zero source handle.
- R6: When a descriptor is written, control bit 3 (completion update) is 1 exactly when the low four bits of its slot index are zero. All other control bits below 24 are 0 at write time.
- R7: A fence strobe sets control bit 4 of the slot (wr_idx − 1) & (2^RING_LOG2−1) and leaves every other field unchanged.
- R8: A start strobe sets control bit 3 of the slot (wr_idx − 1) & (2^RING_LOG2−1). Two cycles after the strobe, db_valid pulses with db_data equal to wr_idx at the strobe. In the same cycle, the started counter takes the accepted count that held at the strobe.
- R9: The handle memory returns, for each slot, the source and destination handles of the job last written there.
- R10: Setting peek_slot shows that slot's descriptor and handles on the peek outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | One-cycle enqueue strobe |
| enq_fill | input | 1 | 1 = fill job, 0 = copy job |
| enq_src | input | 64 | Source address or fill pattern |
| enq_dst | input | 64 | Destination address |
| enq_len | input | 32 | Transfer length in bytes |
| enq_src_hdl | input | 64 | Opaque source handle |
| enq_dst_hdl | input | 64 | Opaque destination handle |
| fence_req | input | 1 | One-cycle fence strobe on the newest descriptor |
| start_req | input | 1 | One-cycle start strobe |
| rd_idx | input | 16 | Consumer's free-running read index |
| space | output | 16 | Free slots |
| wr_idx | output | 16 | Free-running write index |
| resp_valid | output | 1 | Enqueue response pulse |
| resp_accept | output | 1 | 1 = accepted, 0 = refused |
| db_valid | output | 1 | Doorbell write pulse |
| db_data | output | 16 | Doorbell value |
| st_enq | output | 32 | Accepted job count |
| st_fail | output | 32 | Refused job count |
| st_started | output | 32 | Accepted count at last doorbell |
| peek_slot | input | RING_LOG2 | Slot to read back |
| peek_desc | output | 512 | Descriptor in that slot |
| peek_src_hdl | output | 64 | Source handle in that slot |
| peek_dst_hdl | output | 64 | Destination handle in that slot |

## Verification
The enqueue response, the write index and the accepted and refused counters are due one rising edge after the strobe. A descriptor's contents, including flags set by fence or start, appear on the peek port one further edge after peek_slot is set. The doorbell pulse and the started counter are due on the second edge after a start strobe, and the doorbell must be absent on the first. The bench drives every strobe on a falling edge and lowers it at the next falling edge. It samples each result at the falling edge that follows the edge on which that result is due, so every check lands a half period after the register it observes has updated.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int DESC_W   = 512;
  localparam int LEN_W    = 32;
  localparam int ADDR_W   = 64;
  localparam int OPC_W    = 8;
  localparam int BODY_W   = LEN_W + OPC_W + 2 * ADDR_W;
  localparam int CB_CU    = 3;
  localparam int CB_FENCE = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_COPY = 8'h00,
    OPC_FILL = 8'h01
  } dr_opc_e;

  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [OPC_W-1:0]  opc;
    logic [LEN_W-1:0]  len;
  } dr_body_t;
endpackage

// File: rtl/dr_index.sv
module dr_index #(
  parameter int IDX_W     = 16,
  parameter int RING_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enq_valid,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [IDX_W-1:0]     space,
  output logic                 take,
  output logic                 cu_mark,
  output logic [RING_LOG2-1:0] wr_slot,
  output logic [RING_LOG2-1:0] last_slot,
  output logic                 resp_valid,
  output logic                 resp_accept
);
  localparam logic [IDX_W-1:0] SLOTS_M1 = IDX_W'((1 << RING_LOG2) - 1);
  localparam logic [IDX_W-1:0] LOW4     = IDX_W'(15);

  logic [IDX_W-1:0] used;
  logic [IDX_W-1:0] prev;

  assign used      = wr_idx - rd_idx;
  assign space     = SLOTS_M1 - used;
  assign take      = enq_valid && (space != '0);
  assign prev      = wr_idx - IDX_W'(1);
  assign wr_slot   = wr_idx[RING_LOG2-1:0];
  assign last_slot = prev[RING_LOG2-1:0];
  assign cu_mark   = ((wr_idx & SLOTS_M1 & LOW4) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx      <= '0;
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      resp_valid  <= enq_valid;
      resp_accept <= take;
      if (take) wr_idx <= wr_idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/dr_slot_store.sv
module dr_slot_store
  import dr_pkg::*;
#(
  parameter int RING_LOG2 = 5,
  parameter int HDL_W     = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [RING_LOG2-1:0] wslot,
  input  dr_body_t             wbody,
  input  logic                 wcu,
  input  logic [HDL_W-1:0]     wsh,
  input  logic [HDL_W-1:0]     wdh,
  input  logic                 set_fence,
  input  logic                 set_cu,
  input  logic [RING_LOG2-1:0] mark_slot,
  input  logic [RING_LOG2-1:0] peek_slot,
  output logic [DESC_W-1:0]    peek_desc,
  output logic [HDL_W-1:0]     peek_src_hdl,
  output logic [HDL_W-1:0]     peek_dst_hdl
);
  localparam int DEPTH = 1 << RING_LOG2;

  dr_body_t           body_mem [DEPTH];
  logic [2*HDL_W-1:0] hdl_mem  [DEPTH];
  logic [DEPTH-1:0]   cu_f;
  logic [DEPTH-1:0]   fe_f;

  dr_body_t           body_q;
  logic [2*HDL_W-1:0] hdl_q;
  logic               cu_q;
  logic               fe_q;
  logic [31:0]        ctrl;

  // Body and handle arrays: plain write port plus registered read port.
  always_ff @(posedge clk) begin
    if (we) begin
      body_mem[wslot] <= wbody;
      hdl_mem[wslot]  <= {wdh, wsh};
    end
    body_q <= body_mem[peek_slot];
    hdl_q  <= hdl_mem[peek_slot];
  end

  // Flag bits kept in registers so they can be set after the body write.
  always_ff @(posedge clk) begin
    if (rst) begin
      cu_f <= '0;
      fe_f <= '0;
      cu_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      if (we) begin
        cu_f[wslot] <= wcu;
        fe_f[wslot] <= 1'b0;
      end
      if (set_fence) fe_f[mark_slot] <= 1'b1;
      if (set_cu)    cu_f[mark_slot] <= 1'b1;
      cu_q <= cu_f[peek_slot];
      fe_q <= fe_f[peek_slot];
    end
  end

  always_comb begin
    ctrl = '0;
    ctrl[31:24]    = body_q.opc;
    ctrl[CB_CU]    = cu_q;
    ctrl[CB_FENCE] = fe_q;
  end

  assign peek_desc    = {256'b0, 64'b0, body_q.dst, body_q.src, ctrl, body_q.len};
  assign peek_src_hdl = hdl_q[HDL_W-1:0];
  assign peek_dst_hdl = hdl_q[2*HDL_W-1:HDL_W];
endmodule

// File: rtl/dr_counters.sv
module dr_counters #(
  parameter int IDX_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             rej,
  input  logic             start,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] st_enq,
  output logic [CNT_W-1:0] st_fail,
  output logic [CNT_W-1:0] st_started,
  output logic             db_valid,
  output logic [IDX_W-1:0] db_data
);
  logic             pend;
  logic [IDX_W-1:0] pend_idx;
  logic [CNT_W-1:0] pend_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_enq     <= '0;
      st_fail    <= '0;
      st_started <= '0;
      db_valid   <= 1'b0;
      db_data    <= '0;
      pend       <= 1'b0;
      pend_idx   <= '0;
      pend_cnt   <= '0;
    end else begin
      if (acc) st_enq  <= st_enq + CNT_W'(1);
      if (rej) st_fail <= st_fail + CNT_W'(1);
      pend <= start;
      if (start) begin
        pend_idx <= wr_idx;
        pend_cnt <= st_enq;
      end
      db_valid <= pend;
      if (pend) begin
        db_data    <= pend_idx;
        st_started <= pend_cnt;
      end
    end
  end
endmodule

// File: rtl/desc_ring_submit.sv
module desc_ring_submit
  import dr_pkg::*;
#(
  parameter int RING_LOG2 = 5,
  parameter int IDX_W     = 16,
  parameter int CNT_W     = 32,
  parameter int HDL_W     = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enq_valid,
  input  logic                 enq_fill,
  input  logic [ADDR_W-1:0]    enq_src,
  input  logic [ADDR_W-1:0]    enq_dst,
  input  logic [LEN_W-1:0]     enq_len,
  input  logic [HDL_W-1:0]     enq_src_hdl,
  input  logic [HDL_W-1:0]     enq_dst_hdl,
  input  logic                 fence_req,
  input  logic                 start_req,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [IDX_W-1:0]     space,
  output logic [IDX_W-1:0]     wr_idx,
  output logic                 resp_valid,
  output logic                 resp_accept,
  output logic                 db_valid,
  output logic [IDX_W-1:0]     db_data,
  output logic [CNT_W-1:0]     st_enq,
  output logic [CNT_W-1:0]     st_fail,
  output logic [CNT_W-1:0]     st_started,
  input  logic [RING_LOG2-1:0] peek_slot,
  output logic [DESC_W-1:0]    peek_desc,
  output logic [HDL_W-1:0]     peek_src_hdl,
  output logic [HDL_W-1:0]     peek_dst_hdl
);
  logic                 take;
  logic                 cu_mark;
  logic [RING_LOG2-1:0] wr_slot;
  logic [RING_LOG2-1:0] last_slot;
  dr_body_t             wbody;
  logic [HDL_W-1:0]     wsh;

  dr_index #(.IDX_W(IDX_W), .RING_LOG2(RING_LOG2)) u_idx (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .rd_idx(rd_idx),
    .wr_idx(wr_idx), .space(space), .take(take), .cu_mark(cu_mark),
    .wr_slot(wr_slot), .last_slot(last_slot),
    .resp_valid(resp_valid), .resp_accept(resp_accept)
  );

  always_comb begin
    wbody.len = enq_len;
    wbody.opc = enq_fill ? OPC_FILL : OPC_COPY;
    wbody.src = enq_src;
    wbody.dst = enq_dst;
    wsh       = enq_fill ? '0 : enq_src_hdl;
  end

  dr_slot_store #(.RING_LOG2(RING_LOG2), .HDL_W(HDL_W)) u_store (
    .clk(clk), .rst(rst), .we(take), .wslot(wr_slot), .wbody(wbody),
    .wcu(cu_mark), .wsh(wsh), .wdh(enq_dst_hdl),
    .set_fence(fence_req), .set_cu(start_req), .mark_slot(last_slot),
    .peek_slot(peek_slot), .peek_desc(peek_desc),
    .peek_src_hdl(peek_src_hdl), .peek_dst_hdl(peek_dst_hdl)
  );

  dr_counters #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .acc(take), .rej(enq_valid && !take),
    .start(start_req), .wr_idx(wr_idx),
    .st_enq(st_enq), .st_fail(st_fail), .st_started(st_started),
    .db_valid(db_valid), .db_data(db_data)
  );
endmodule

// File: rtl/dr_submit_chk.sv
module dr_submit_chk #(
  parameter int IDX_W = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_valid,
  input logic             fence_req,
  input logic             start_req,
  input logic [IDX_W-1:0] space,
  input logic [IDX_W-1:0] wr_idx,
  input logic             resp_valid,
  input logic             resp_accept,
  input logic [CNT_W-1:0] st_fail,
  input logic             db_valid,
  input logic [IDX_W-1:0] db_data
);
  p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({enq_valid, fence_req, start_req}));

  p_accept_step_r2: assert property (@(posedge clk) disable iff (rst)
    enq_valid && (space != '0) |=> resp_valid && resp_accept && (wr_idx == $past(wr_idx) + IDX_W'(1)));

  p_resp_source_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(enq_valid));

  p_refuse_hold_r3: assert property (@(posedge clk) disable iff (rst)
    enq_valid && (space == '0) |=> resp_valid && !resp_accept && $stable(wr_idx)
      && (st_fail == $past(st_fail) + CNT_W'(1)));

  p_doorbell_due_r8: assert property (@(posedge clk) disable iff (rst)
    start_req |-> ##2 db_valid);

  p_doorbell_value_r8: assert property (@(posedge clk) disable iff (rst)
    db_valid |-> db_data == $past(wr_idx, 2));
endmodule

bind desc_ring_submit dr_submit_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enq_valid(enq_valid), .fence_req(fence_req),
  .start_req(start_req), .space(space), .wr_idx(wr_idx),
  .resp_valid(resp_valid), .resp_accept(resp_accept), .st_fail(st_fail),
  .db_valid(db_valid), .db_data(db_data)
);

// File: tb/sim_desc_ring_submit.sv
`timescale 1ns/1ps
module sim_desc_ring_submit;
  localparam int RL = 5;
  localparam int NS = 1 << RL;
  localparam int MSK = NS - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enq_valid = 0, enq_fill = 0, fence_req = 0, start_req = 0;
  logic [63:0] enq_src = '0, enq_dst = '0, enq_src_hdl = '0, enq_dst_hdl = '0;
  logic [31:0] enq_len = '0;
  logic [15:0] rd_idx = '0;
  logic [RL-1:0] peek_slot = '0;
  logic [15:0] space, wr_idx, db_data;
  logic resp_valid, resp_accept, db_valid;
  logic [31:0] st_enq, st_fail, st_started;
  logic [511:0] peek_desc;
  logic [63:0] peek_src_hdl, peek_dst_hdl;

  desc_ring_submit #(.RING_LOG2(RL)) u0 (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_len [NS];
  logic [31:0] m_ctrl [NS];
  logic [63:0] m_src [NS], m_dst [NS], m_sh [NS], m_dh [NS];
  bit          m_wrt [NS];
  logic [15:0] m_wr = 0, m_rd = 0;
  logic [31:0] m_enq = 0, m_fail = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_space();
    return 16'(16'(MSK) - (m_wr - m_rd));
  endfunction

  function automatic logic [31:0] new_ctrl(bit fill, int slot);
    logic [31:0] c;
    c = fill ? 32'h0100_0000 : 32'h0;
    if ((slot & 15) == 0) c[3] = 1'b1;
    return c;
  endfunction

  task automatic do_enq(bit fill, logic [63:0] s, logic [63:0] d, logic [31:0] l,
                        logic [63:0] sh, logic [63:0] dh);
    bit exp_acc;
    int slot;
    exp_acc = (exp_space() != 0);
    chk(space == exp_space(), "R2", "space", space, exp_space());
    enq_valid = 1; enq_fill = fill; enq_src = s; enq_dst = d; enq_len = l;
    enq_src_hdl = sh; enq_dst_hdl = dh;
    @(negedge clk);
    enq_valid = 0;
    slot = int'(m_wr) & MSK;
    if (exp_acc) begin
      m_len[slot] = l; m_src[slot] = s; m_dst[slot] = d;
      m_sh[slot] = fill ? 64'h0 : sh; m_dh[slot] = dh;
      m_ctrl[slot] = new_ctrl(fill, slot); m_wrt[slot] = 1;
      m_wr = m_wr + 1; m_enq = m_enq + 1;
      chk(resp_valid && resp_accept, "R2", "accept response", {resp_valid, resp_accept}, 2'b11);
    end else begin
      m_fail = m_fail + 1;
      chk(resp_valid && !resp_accept, "R3", "refuse response", {resp_valid, resp_accept}, 2'b10);
    end
    chk(wr_idx == m_wr, exp_acc ? "R2" : "R3", "wr_idx", wr_idx, m_wr);
    chk(st_enq == m_enq, "R2", "accepted count", st_enq, m_enq);
    chk(st_fail == m_fail, "R3", "refused count", st_fail, m_fail);
  endtask

  task automatic do_fence();
    fence_req = 1;
    @(negedge clk);
    fence_req = 0;
    m_ctrl[(int'(m_wr) - 1) & MSK][4] = 1'b1;
  endtask

  task automatic do_start();
    logic [15:0] e_db;
    logic [31:0] e_st;
    start_req = 1;
    e_db = m_wr; e_st = m_enq;
    m_ctrl[(int'(m_wr) - 1) & MSK][3] = 1'b1;
    @(negedge clk);
    start_req = 0;
    chk(!db_valid, "R8", "doorbell early", db_valid, 0);
    @(negedge clk);
    chk(db_valid, "R8", "doorbell pulse", db_valid, 1);
    chk(db_data == e_db, "R8", "doorbell value", db_data, e_db);
    chk(st_started == e_st, "R8", "started count", st_started, e_st);
  endtask

  task automatic check_slot(int s, string req);
    peek_slot = RL'(s);
    @(negedge clk);
    if (m_wrt[s]) begin
      chk(peek_desc[31:0] == m_len[s], "R4", "length field", peek_desc[31:0], m_len[s]);
      chk(peek_desc[63:32] == m_ctrl[s], req, "control word", peek_desc[63:32], m_ctrl[s]);
      chk(peek_desc[127:64] == m_src[s], "R5", "source field", peek_desc[127:64], m_src[s]);
      chk(peek_desc[191:128] == m_dst[s], "R4", "destination field", peek_desc[191:128], m_dst[s]);
      chk(peek_desc[511:192] == '0, "R4", "upper zero", peek_desc[255:192], 0);
      chk(peek_src_hdl == m_sh[s], "R9", "source handle", peek_src_hdl, m_sh[s]);
      chk(peek_dst_hdl == m_dh[s], "R10", "destination handle", peek_dst_hdl, m_dh[s]);
    end
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < NS; i++) begin m_wrt[i] = 0; m_ctrl[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(wr_idx == 0, "R1", "wr_idx", wr_idx, 0);
    chk(!resp_valid && !db_valid, "R1", "pulses", {resp_valid, db_valid}, 0);
    chk(st_enq == 0 && st_fail == 0 && st_started == 0, "R1", "counters", st_enq | st_fail | st_started, 0);
    peek_slot = '0;
    @(negedge clk);
    chk(peek_desc[63:32] == 0, "R1", "flags clear", peek_desc[63:32], 0);

    // directed: copy at slot 0 (R6 flag), fill at slot 1 (R5)
    do_enq(0, 64'h1000, 64'h2000, 32'd64, 64'hAAAA, 64'hBBBB);
    do_enq(1, 64'hDEAD_BEEF_0123_4567, 64'h3000, 32'd128, 64'hCCCC, 64'hDDDD);
    check_slot(0, "R6");
    check_slot(1, "R5");
    // fill the ring: 31 accepted then refused (R3)
    for (int i = 2; i < NS; i++) do_enq(i[0], r64(), r64(), $urandom, r64(), r64());
    do_enq(0, r64(), r64(), 32'd1, r64(), r64());
    check_slot(16, "R6");
    // fence and start on slot 30 (R7, R8)
    do_fence();
    check_slot(30, "R7");
    do_start();
    check_slot(30, "R8");
    // read side advances; wrap; then full again
    m_rd = 16'd20; rd_idx = m_rd;
    @(negedge clk);
    for (int i = 0; i < 20; i++) do_enq(0, r64(), r64(), $urandom, r64(), r64());
    do_enq(1, r64(), r64(), 32'd9, r64(), r64());
    check_slot(int'(m_wr) & MSK, "R3");
    // read index ahead by a gap near the limit (R2)
    m_rd = m_wr - 16'd5; rd_idx = m_rd;
    @(negedge clk);
    chk(space == 16'd26, "R2", "space after read advance", space, 26);

    // random phase
    for (int it = 0; it < 800; it++) begin
      int r;
      r = $urandom % 10;
      if (r < 6) do_enq($urandom % 2, r64(), r64(), $urandom, r64(), r64());
      else if (r == 6) do_fence();
      else if (r == 7) do_start();
      else if (r == 8) begin
        m_rd = m_rd + 16'($urandom % (32'(16'(m_wr - m_rd)) + 1));
        rd_idx = m_rd;
        @(negedge clk);
      end else check_slot($urandom % NS, "R4");
    end
    for (int s = 0; s < NS; s++) check_slot(s, "R7");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule